// File: doc/BRIEF.md
# SMRAM access control and remap

This block sits on the memory-controller side of a processor bus. It holds an 8-bit control register that decides whether two protected system-management memory windows are decoded. The first is a fixed high window just below 4 GB, which is redirected onto the legacy low SMRAM region at 000A0000h. The second is a top segment whose inclusive base and limit are supplied from outside. Each enable bit works only when the global SMRAM enable input is also high.

Every processor access presents an address together with three qualifiers: whether the processor is in system-management mode, the global enable, and an open-override. From these the block produces a hit indication and the DRAM address to use, both combinationally. Any hit made outside system-management mode while the override is low sets a sticky violation flag, and software clears that flag by writing 1 to it.

A lock input freezes both enable bits. The block latches the lock internally, so once it has been seen it lasts until reset.

Top module: `smram_access_ctrl`

## Requirements
- R1: After reset the register reads 38h: both enables are 0, the violation flag is 0, bits 5:3 are 1 and the other bits are 0.
- R2: Bits 5, 4 and 3 always read 1 and bits 2:1 always read 0, whatever value is written.
- R3: When the global enable and bit 7 (high-window enable) are both 1, a valid access in FEDA0000h..FEDBFFFFh asserts hit_o, and dram_addr_o equals 000A0000h OR'ed with the low 17 address bits.
- R4: When the global enable and bit 0 (top-segment enable) are both 1, a valid access with tseg_base_i <= address <= tseg_limit_i asserts hit_o, and dram_addr_o equals the address.
- R5: With no valid access, with the global enable at 0, with the matching enable bit at 0, or with the address outside both windows, hit_o is 0 and dram_addr_o equals the address.
- R6: A hit while acc_in_smm_i is 0 and acc_open_i is 0 sets bit 6 (err_o) at the next clock edge.
- R7: A hit with acc_in_smm_i = 1 or acc_open_i = 1 leaves bit 6 unchanged.
- R8: Writing 1 to bit 6 clears it at the next edge. Writing 0 to bit 6 leaves it unchanged.
- R9: If a violation and a write-1 clear of bit 6 happen in the same cycle, bit 6 ends up set.
- R10: When lock_i is high, or has been high at any edge since reset, writes do not change bits 7 and 0. Bit 6 can still be cleared while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| lock_i | input | 1 | Lock request for the enable bits, latched internally |
| glb_en_i | input | 1 | Global SMRAM enable |
| acc_valid_i | input | 1 | Processor access valid |
| acc_addr_i | input | 32 | Processor access address |
| acc_in_smm_i | input | 1 | Processor is in system-management mode |
| acc_open_i | input | 1 | Open-override, which suppresses violation reporting |
| tseg_base_i | input | 32 | Top segment first address |
| tseg_limit_i | input | 32 | Top segment last address |
| hit_o | output | 1 | Access falls in an enabled protected window |
| dram_addr_o | output | 32 | DRAM address after any remap |
| err_o | output | 1 | Sticky violation flag (register bit 6) |

## Verification
The addresses probed are the two edges of the high window and the addresses just beyond each edge, together with the top segment's base, its limit and its outer neighbours. These separate inclusive from exclusive compares and off-by-one decode faults. Each window is also tried with only one enable set, with the global enable low and with the access invalid, which shows whether the AND of the two enables is complete. Violations are raised in three ways: outside system-management mode, inside it, and with the override high. The clear is tried with both polarities of bit 6 and again in the same cycle as a violation, which exposes priority and polarity faults. Writes are made while lock_i is high, after it has been released, and in the very cycle it rises, which shows whether the lock is latched and applied at once.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int ADDR_W   = 32;
  localparam int WIN_BITS = 17;  // both windows span 128 KiB
  localparam int UP_W     = ADDR_W - WIN_BITS;

  localparam logic [ADDR_W-1:0] HI_WIN_BASE = 32'hFEDA_0000;
  localparam logic [ADDR_W-1:0] LO_WIN_BASE = 32'h000A_0000;

  // register bit positions
  localparam int B_HEN = 7;
  localparam int B_ERR = 6;
  localparam int B_TEN = 0;
  localparam logic [2:0] RO_ONES = 3'b111;

  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/smram_decode.sv
module smram_decode
  import smram_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  addr_t addr_i,
  input  logic  glb_en_i,
  input  logic  hen_i,
  input  logic  ten_i,
  input  addr_t tseg_base_i,
  input  addr_t tseg_limit_i,
  input  logic  in_smm_i,
  input  logic  open_i,
  output logic  hit_o,
  output addr_t dram_addr_o,
  output logic  viol_o
);
  logic in_hi, in_ts, hi_hit, ts_hit;

  assign in_hi  = addr_i[ADDR_W-1:WIN_BITS] == HI_WIN_BASE[ADDR_W-1:WIN_BITS];
  assign in_ts  = (addr_i >= tseg_base_i) && (addr_i <= tseg_limit_i);
  assign hi_hit = valid_i && glb_en_i && hen_i && in_hi;
  assign ts_hit = valid_i && glb_en_i && ten_i && in_ts;

  always_comb begin
    dram_addr_o = addr_i;
    if (hi_hit) dram_addr_o = {LO_WIN_BASE[ADDR_W-1:WIN_BITS], addr_i[WIN_BITS-1:0]};
  end

  assign hit_o  = hi_hit || ts_hit;
  assign viol_o = hit_o && !in_smm_i && !open_i;

  AST_OFF_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i || !valid_i) |-> (!hit_o && dram_addr_o == addr_i)); // R5
  AST_REMAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_addr_o != addr_i) |-> (hit_o && dram_addr_o[ADDR_W-1:WIN_BITS] == LO_WIN_BASE[ADDR_W-1:WIN_BITS])); // R3
  AST_SMM_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_smm_i || open_i) |-> !viol_o); // R7
endmodule

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
  import smram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       lock_i,
  input  logic       viol_i,
  output logic       hen_o,
  output logic       ten_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);
  logic lock_q, locked, hen_q, ten_q, err_q, err_clr;

  assign locked  = lock_q || lock_i;  // lock takes effect in the cycle it rises
  assign err_clr = wr_i && wdata_i[B_ERR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      hen_q  <= 1'b0;
      ten_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lock_q <= locked;
      if (wr_i && !locked) begin
        hen_q <= wdata_i[B_HEN];
        ten_q <= wdata_i[B_TEN];
      end
      err_q <= viol_i || (err_q && !err_clr);  // set beats clear
    end
  end

  assign hen_o   = hen_q;
  assign ten_o   = ten_q;
  assign err_o   = err_q;
  assign rdata_o = {hen_q, err_q, RO_ONES, 2'b00, ten_q};

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i || lock_q) |=> ($stable(hen_q) && $stable(ten_q))); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R10
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> err_q); // R9
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr && !viol_i) |=> !err_q); // R8
  AST_ERR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr) |=> err_q); // R8
endmodule

// File: rtl/smram_access_ctrl.sv
module smram_access_ctrl
  import smram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              lock_i,
  input  logic              glb_en_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_in_smm_i,
  input  logic              acc_open_i,
  input  logic [ADDR_W-1:0] tseg_base_i,
  input  logic [ADDR_W-1:0] tseg_limit_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic              err_o
);
  logic hen, ten, viol;

  smram_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .lock_i  (lock_i),
    .viol_i  (viol),
    .hen_o   (hen),
    .ten_o   (ten),
    .err_o   (err_o),
    .rdata_o (reg_rdata_o)
  );

  smram_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (acc_valid_i),
    .addr_i       (acc_addr_i),
    .glb_en_i     (glb_en_i),
    .hen_i        (hen),
    .ten_i        (ten),
    .tseg_base_i  (tseg_base_i),
    .tseg_limit_i (tseg_limit_i),
    .in_smm_i     (acc_in_smm_i),
    .open_i       (acc_open_i),
    .hit_o        (hit_o),
    .dram_addr_o  (dram_addr_o),
    .viol_o       (viol)
  );

  AST_RESET_VALUE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (reg_rdata_o == 8'h38)); // R1
endmodule

// File: tb/tb_smram_access_ctrl.sv
module tb_smram_access_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic        lock_i = 1'b0, glb_en_i = 1'b0, acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = 32'h0;
  logic        acc_in_smm_i = 1'b0, acc_open_i = 1'b0;
  logic [31:0] tseg_base_i = 32'h7F00_0000, tseg_limit_i = 32'h7F7F_FFFF;
  logic        hit_o, err_o;
  logic [31:0] dram_addr_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  // reference state
  bit m_hen, m_ten, m_err, m_lock;

  smram_access_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // compare all outputs against the model, then advance one clock
  task automatic step(input string tag);
    bit in_hi, in_ts, hh, th, viol, lk;
    logic [31:0] e_addr;
    #2;
    in_hi = acc_addr_i >= 32'hFEDA_0000 && acc_addr_i <= 32'hFEDB_FFFF;
    in_ts = acc_addr_i >= tseg_base_i && acc_addr_i <= tseg_limit_i;
    hh = acc_valid_i && glb_en_i && m_hen && in_hi;
    th = acc_valid_i && glb_en_i && m_ten && in_ts;
    e_addr = hh ? (32'h000A_0000 + (acc_addr_i & 32'h0001_FFFF)) : acc_addr_i;
    chk({tag, " hit"}, {31'b0, hit_o}, {31'b0, hh || th});
    chk({tag, " addr"}, dram_addr_o, e_addr);
    chk({tag, " rdata"}, {24'b0, reg_rdata_o}, {24'b0, m_hen, m_err, 3'b111, 2'b00, m_ten});
    chk({tag, " err"}, {31'b0, err_o}, {31'b0, m_err});
    viol = (hh || th) && !acc_in_smm_i && !acc_open_i;
    lk = m_lock || lock_i;
    @(posedge clk_i);
    if (reg_wr_i && !lk) begin m_hen = reg_wdata_i[7]; m_ten = reg_wdata_i[0]; end
    m_err = viol || (m_err && !(reg_wr_i && reg_wdata_i[6]));
    m_lock = lk;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input bit smm, input bit opn, input string tag);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_in_smm_i = smm; acc_open_i = opn;
    step(tag);
    acc_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    step(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step("R1 reset");
    wr(8'h3E, "R2 ro bits");          // enables stay 0, bit6 W1C on clear flag
    step("R2 readback");
    glb_en_i = 1'b1;
    acc(32'hFEDA_0000, 1, 0, "R5 hen clear");
    acc(32'h7F00_0000, 1, 0, "R5 ten clear");
    wr(8'h81, "R3 enable");
    acc(32'hFEDA_0000, 1, 0, "R3 low edge");
    acc(32'hFEDB_FFFF, 1, 0, "R3 high edge");
    acc(32'hFEDA_1234, 1, 0, "R3 mid");
    acc(32'hFED9_FFFF, 1, 0, "R5 below hi");
    acc(32'hFEDC_0000, 1, 0, "R5 above hi");
    acc(32'h7F00_0000, 1, 0, "R4 base");
    acc(32'h7F7F_FFFF, 1, 0, "R4 limit");
    acc(32'h7EFF_FFFF, 1, 0, "R5 below ts");
    acc(32'h7F80_0000, 1, 0, "R5 above ts");
    step("R5 no valid");
    glb_en_i = 1'b0;
    acc(32'hFEDA_0040, 0, 0, "R5 glb off");
    step("R6 no set when off");
    glb_en_i = 1'b1;
    acc(32'hFEDA_0040, 1, 0, "R7 smm");
    acc(32'h7F00_0100, 0, 1, "R7 open");
    step("R7 flag clear");
    acc(32'hFEDB_0000, 0, 0, "R6 viol hi");
    step("R6 flag set");
    wr(8'h81, "R8 write 0");
    step("R8 still set");
    wr(8'hC1, "R8 write 1");
    step("R8 cleared");
    acc(32'h7F10_0000, 0, 0, "R6 viol ts");
    reg_wr_i = 1'b1; reg_wdata_i = 8'hC1;
    acc(32'h7F10_0000, 0, 0, "R9 set and clear");
    step("R9 set wins");
    wr(8'h01, "R10 prelock write");   // also clears via bit6=0? no: bit6 clear needs 1
    wr(8'h81, "R10 restore");
    lock_i = 1'b1;
    wr(8'h00, "R10 write on lock edge");
    lock_i = 1'b0;
    step("R10 held");
    wr(8'h40, "R10 after release");
    step("R10 still held");
    acc(32'hFEDA_0000, 1, 0, "R10 hi still on");
    wr(8'hFF, "R2 all ones");
    step("R2 readback ones");
    rst_ni = 1'b0; m_hen = 0; m_ten = 0; m_err = 0; m_lock = 0;
    @(negedge clk_i); rst_ni = 1'b1;
    wr(8'h81, "R10 lock cleared by reset");
    step("R10 unlocked");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule